// File: doc/BRIEF.md
# Two-Part Long Call Sequencer

This block executes the long subroutine call of a compact 16-bit instruction set. That call is split across two halfwords. The first halfword builds the upper part of the target, adds it to the program-counter read value, and leaves the sum in the link register. The second halfword adds a low offset to the link register to form the jump target, and writes the return address back into the link register. A variant of the second halfword also switches the core out of the compact instruction state and forces the target onto a word boundary.

Each step supplies a 32-bit fetch word that carries the current halfword and the halfword after it. When a first half is followed by a matching second half, the block consumes both in one step. When it is not, only the link register is updated. A second half that arrives on its own is also executed. In that case it uses whatever value the link register currently holds. The result is only meaningful if an earlier first half set that value up.

Results are registered and appear one cycle after the step. The register file and the fetch path sit outside this block. The surrounding pipeline applies the write strobes and uses the flush pulse to discard the instructions it has already fetched.

Top module: `far_call_unit`

## Requirements
- R1: When `big_end`=1, the current halfword is `fetch_word[31:16]` and the following halfword is `fetch_word[15:0]`. When `big_end`=0, the two are swapped.
- R2: A current halfword with opcode field [15:11]=30 writes `link_out` = `pc_read` + (sign-extended field [10:0] shifted left by 12). It raises `link_we` and reports `status`=01 (branch).
- R3: When the following halfword has opcode 31, the same step also writes `pc_out` = (the R2 link value) + (its field [10:0] shifted left by 1). It raises `pc_we`, and `link_out` becomes (`pc_cur`+4) with bit 0 set.
- R4: When the following halfword has opcode 29 with `isa_v5`=1 and bit 0 clear, the target is (the R2 link value + field [10:1] shifted left by 2) with bits [1:0] cleared. `state_clr` is raised and `link_out` becomes (`pc_cur`+4)|1.
- R5: When the following halfword after opcode 30 is neither a valid 31 nor a valid 29, only the R2 link update is made. `pc_we` and `state_clr` stay 0.
- R6: A current halfword with opcode 31 writes `pc_out` = `link_in` + (field [10:0] shifted left by 1) and `link_out` = (`pc_cur`+2)|1, and reports branch.
- R7: A current halfword with opcode 29 and `isa_v5`=1 and bit 0 clear writes `pc_out` = (`link_in` + field [10:0] shifted left by 1) with bits [1:0] cleared. It writes `link_out` = (`pc_cur`+2)|1, raises `state_clr` and reports branch. Any other opcode-29 halfword reports `status`=10 (undefined) and raises no strobe.
- R8: Any other opcode reports `status`=00 (not handled) and raises no strobe.
- R9: All results appear in the cycle after `step` is high. `done`, `pc_we`, `link_we`, `state_clr` and `flush` are one-cycle pulses. `flush` is high exactly when `pc_we` is high.
- R10: Synchronous reset clears every strobe, `pc_out`, `link_out` and `status` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Process the fetch word this cycle |
| fetch_word | input | 2*HW | Current and following halfword |
| big_end | input | 1 | Selects which half of the fetch word is current |
| isa_v5 | input | 1 | Enables the exchanging second half |
| pc_cur | input | XLEN | Address of the current halfword |
| pc_read | input | XLEN | Program counter as read by an instruction |
| link_in | input | XLEN | Current link register |
| pc_out | output | XLEN | New program counter |
| pc_we | output | 1 | Program counter write strobe |
| link_out | output | XLEN | New link register value |
| link_we | output | 1 | Link register write strobe |
| state_clr | output | 1 | Clear the compact-instruction state bit |
| flush | output | 1 | Discard fetched instructions |
| status | output | 2 | 00 not handled, 01 branch, 10 undefined |
| done | output | 1 | Result valid pulse |

## Verification
The bench builds the block with its defaults, XLEN=32 and HW=16. These are the only values at which the opcode field and the 11-bit offset keep their fixed positions, so every target and return value is compared at full width. With these sizes, negative high offsets wrap across bit 31, and a link value with odd low bits shows whether the exchanging variant masks to word alignment. The stimulus drives both fetch-word orders and both offset signs, with the version flag on and off.

// File: rtl/far_call_pkg.sv
package far_call_pkg;
  typedef enum logic [1:0] {
    ST_NONE   = 2'b00,
    ST_BRANCH = 2'b01,
    ST_UNDEF  = 2'b10
  } fc_status_e;

  typedef enum logic [2:0] {
    K_OTHER,
    K_HI_LO,
    K_HI_LOX,
    K_HI_ONLY,
    K_LO,
    K_LOX,
    K_LOX_BAD
  } fc_kind_e;

  localparam int OPW = 5;
  localparam logic [OPW-1:0] OP_HI  = 5'd30;
  localparam logic [OPW-1:0] OP_LO  = 5'd31;
  localparam logic [OPW-1:0] OP_LOX = 5'd29;
endpackage

// File: rtl/fc_half_sel.sv
module fc_half_sel #(
  parameter int HW = 16
) (
  input  logic [2*HW-1:0] word,
  input  logic            big,
  output logic [HW-1:0]   cur,
  output logic [HW-1:0]   nxt
);
  always_comb begin
    if (big) begin
      cur = word[2*HW-1:HW];
      nxt = word[HW-1:0];
    end else begin
      cur = word[HW-1:0];
      nxt = word[2*HW-1:HW];
    end
  end
endmodule

// File: rtl/fc_classify.sv
module fc_classify
  import far_call_pkg::*;
#(
  parameter int HW = 16
) (
  input  logic [HW-1:0] cur,
  input  logic [HW-1:0] nxt,
  input  logic          v5,
  output fc_kind_e      kind
);
  localparam int OPL = HW - OPW;

  logic [OPW-1:0] op_c, op_n;
  logic           nxt_lox_ok, cur_lox_ok;

  assign op_c       = cur[HW-1:OPL];
  assign op_n       = nxt[HW-1:OPL];
  assign nxt_lox_ok = v5 && !nxt[0];
  assign cur_lox_ok = v5 && !cur[0];

  always_comb begin
    kind = K_OTHER;
    if (op_c == OP_HI) begin
      if (op_n == OP_LO)                      kind = K_HI_LO;
      else if (op_n == OP_LOX && nxt_lox_ok)  kind = K_HI_LOX;
      else                                    kind = K_HI_ONLY;
    end else if (op_c == OP_LO) begin
      kind = K_LO;
    end else if (op_c == OP_LOX) begin
      kind = cur_lox_ok ? K_LOX : K_LOX_BAD;
    end
  end
endmodule

// File: rtl/fc_addr_gen.sv
module fc_addr_gen
  import far_call_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int HW   = 16
) (
  input  fc_kind_e        kind,
  input  logic [HW-1:0]   cur,
  input  logic [HW-1:0]   nxt,
  input  logic [XLEN-1:0] pc_cur,
  input  logic [XLEN-1:0] pc_read,
  input  logic [XLEN-1:0] link_in,
  output logic [XLEN-1:0] tgt,
  output logic [XLEN-1:0] link_new,
  output logic            pc_wr,
  output logic            link_wr,
  output logic            xclr,
  output fc_status_e      st
);
  localparam int OFFW   = HW - OPW;
  localparam int HISH   = 12;
  localparam int SEXTW  = XLEN - OFFW - HISH;
  localparam int ZPADW  = XLEN - OFFW - 1;

  logic [XLEN-1:0] hi_link, low_base, lo_off, lox_off, sum_lo, sum_lox;
  logic [HW-1:0]   low_hw;
  logic            paired;

  assign hi_link  = pc_read + {{SEXTW{cur[OFFW-1]}}, cur[OFFW-1:0], {HISH{1'b0}}};
  assign paired   = (kind == K_HI_LO) || (kind == K_HI_LOX);
  assign low_hw   = paired ? nxt : cur;
  assign low_base = paired ? hi_link : link_in;
  assign lo_off   = {{ZPADW{1'b0}}, low_hw[OFFW-1:0], 1'b0};
  assign lox_off  = {{ZPADW{1'b0}}, low_hw[OFFW-1:1], 2'b00};
  assign sum_lo   = low_base + lo_off;
  assign sum_lox  = low_base + lox_off;

  always_comb begin
    tgt      = '0;
    link_new = '0;
    pc_wr    = 1'b0;
    link_wr  = 1'b0;
    xclr     = 1'b0;
    st       = ST_NONE;
    case (kind)
      K_HI_ONLY: begin
        link_new = hi_link;
        link_wr  = 1'b1;
        st       = ST_BRANCH;
      end
      K_HI_LO, K_LO: begin
        tgt      = sum_lo;
        link_new = (pc_cur + (paired ? XLEN'(4) : XLEN'(2))) | XLEN'(1);
        pc_wr    = 1'b1;
        link_wr  = 1'b1;
        st       = ST_BRANCH;
      end
      K_HI_LOX, K_LOX: begin
        tgt      = {sum_lox[XLEN-1:2], 2'b00};
        link_new = (pc_cur + (paired ? XLEN'(4) : XLEN'(2))) | XLEN'(1);
        pc_wr    = 1'b1;
        link_wr  = 1'b1;
        xclr     = 1'b1;
        st       = ST_BRANCH;
      end
      K_LOX_BAD: st = ST_UNDEF;
      default:   st = ST_NONE;
    endcase
  end
endmodule

// File: rtl/far_call_unit.sv
module far_call_unit
  import far_call_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int HW   = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  input  logic [2*HW-1:0] fetch_word,
  input  logic            big_end,
  input  logic            isa_v5,
  input  logic [XLEN-1:0] pc_cur,
  input  logic [XLEN-1:0] pc_read,
  input  logic [XLEN-1:0] link_in,
  output logic [XLEN-1:0] pc_out,
  output logic            pc_we,
  output logic [XLEN-1:0] link_out,
  output logic            link_we,
  output logic            state_clr,
  output logic            flush,
  output logic [1:0]      status,
  output logic            done
);
  logic [HW-1:0]   cur_hw, nxt_hw;
  fc_kind_e        kind;
  logic [XLEN-1:0] tgt_c, link_c;
  logic            pcw_c, lw_c, xclr_c;
  fc_status_e      st_c;

  fc_half_sel #(.HW(HW)) u_sel (
    .word(fetch_word), .big(big_end), .cur(cur_hw), .nxt(nxt_hw)
  );

  fc_classify #(.HW(HW)) u_cls (
    .cur(cur_hw), .nxt(nxt_hw), .v5(isa_v5), .kind(kind)
  );

  fc_addr_gen #(.XLEN(XLEN), .HW(HW)) u_gen (
    .kind(kind), .cur(cur_hw), .nxt(nxt_hw), .pc_cur(pc_cur),
    .pc_read(pc_read), .link_in(link_in), .tgt(tgt_c), .link_new(link_c),
    .pc_wr(pcw_c), .link_wr(lw_c), .xclr(xclr_c), .st(st_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_out    <= '0;
      link_out  <= '0;
      pc_we     <= 1'b0;
      link_we   <= 1'b0;
      state_clr <= 1'b0;
      flush     <= 1'b0;
      status    <= ST_NONE;
      done      <= 1'b0;
    end else begin
      done      <= step;
      pc_we     <= step && pcw_c;
      flush     <= step && pcw_c;
      link_we   <= step && lw_c;
      state_clr <= step && xclr_c;
      if (step) begin
        pc_out   <= tgt_c;
        link_out <= link_c;
        status   <= st_c;
      end
    end
  end
endmodule

// File: rtl/far_call_unit_chk.sv
module far_call_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            step,
  input logic [XLEN-1:0] pc_out,
  input logic            pc_we,
  input logic [XLEN-1:0] link_out,
  input logic            link_we,
  input logic            state_clr,
  input logic            flush,
  input logic [1:0]      status,
  input logic            done
);
  a_r9_done_follows_step: assert property (@(posedge clk) disable iff (rst)
    step |=> done);
  a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    !step |=> !(done || pc_we || link_we || flush || state_clr));
  a_r9_flush_with_pc: assert property (@(posedge clk) disable iff (rst)
    flush |-> (pc_we && done));
  a_r4_exchange_aligned: assert property (@(posedge clk) disable iff (rst)
    (pc_we && state_clr) |-> (pc_out[1:0] == 2'b00));
  a_r7_undef_no_write: assert property (@(posedge clk) disable iff (rst)
    (done && status == 2'b10) |-> !(pc_we || link_we || state_clr));
  a_r3_return_odd: assert property (@(posedge clk) disable iff (rst)
    pc_we |-> (link_we && link_out[0]));
endmodule

bind far_call_unit far_call_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .step(step), .pc_out(pc_out), .pc_we(pc_we),
  .link_out(link_out), .link_we(link_we), .state_clr(state_clr),
  .flush(flush), .status(status), .done(done)
);

// File: tb/far_call_unit_bench.sv
module far_call_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;

  typedef struct packed {
    logic        big;
    logic        v5;
    logic [31:0] word;
    logic [31:0] pc;
    logic [31:0] pcr;
    logic [31:0] lr;
  } vec_t;

  typedef struct packed {
    logic        pcw;
    logic [31:0] pc;
    logic        lrw;
    logic [31:0] lr;
    logic        xc;
    logic [1:0]  st;
  } res_t;

  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 32'hF810_F001, 32'h0000_1000, 32'h0000_1004, 32'h0},
    '{1'b1, 1'b0, 32'hF7FF_F803, 32'h0000_0200, 32'h0000_0204, 32'h0},
    '{1'b0, 1'b1, 32'hE906_F002, 32'h0000_3002, 32'h0000_3006, 32'h0},
    '{1'b0, 1'b1, 32'h1C08_F005, 32'h0000_4000, 32'h0000_4004, 32'h0},
    '{1'b1, 1'b0, 32'hF821_4000, 32'h0000_5000, 32'h0000_5004, 32'h1234_5000},
    '{1'b0, 1'b1, 32'h0000_E87E, 32'h0000_6000, 32'h0000_6004, 32'h1234_5677},
    '{1'b0, 1'b1, 32'h0000_E87F, 32'h0000_7000, 32'h0000_7004, 32'h1234_5677},
    '{1'b0, 1'b0, 32'h0000_E87E, 32'h0000_8000, 32'h0000_8004, 32'h1234_5677},
    '{1'b1, 1'b1, 32'h4770_0000, 32'h0000_9000, 32'h0000_9004, 32'h0},
    '{1'b0, 1'b0, 32'hE906_F002, 32'h0000_A000, 32'h0000_A004, 32'h0},
    '{1'b1, 1'b1, 32'hF400_E801, 32'h0000_B000, 32'h0000_B004, 32'h0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step = 1'b0;
  logic [31:0] fetch_word = '0;
  logic        big_end = 1'b0;
  logic        isa_v5 = 1'b0;
  logic [31:0] pc_cur = '0, pc_read = '0, link_in = '0;
  logic [31:0] pc_out, link_out;
  logic        pc_we, link_we, state_clr, flush, done;
  logic [1:0]  status;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  far_call_unit u_far_call_unit (
    .clk(clk), .rst(rst), .step(step), .fetch_word(fetch_word),
    .big_end(big_end), .isa_v5(isa_v5), .pc_cur(pc_cur), .pc_read(pc_read),
    .link_in(link_in), .pc_out(pc_out), .pc_we(pc_we), .link_out(link_out),
    .link_we(link_we), .state_clr(state_clr), .flush(flush),
    .status(status), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int sx11(input logic [10:0] f);
    return f[10] ? int'(f) - 2048 : int'(f);
  endfunction

  function automatic res_t model(input vec_t v);
    res_t r;
    logic [15:0] c, n;
    logic [31:0] hl;
    r = '0;
    c = v.big ? v.word[31:16] : v.word[15:0];
    n = v.big ? v.word[15:0] : v.word[31:16];
    if (c[15:11] == 5'd30) begin
      hl = v.pcr + 32'(sx11(c[10:0]) * 4096);
      r.lrw = 1'b1; r.lr = hl; r.st = 2'b01;
      if (n[15:11] == 5'd31) begin
        r.pcw = 1'b1; r.pc = hl + 32'(int'(n[10:0]) * 2);
        r.lr = (v.pc + 32'd4) | 32'd1;
      end else if (n[15:11] == 5'd29 && v.v5 && n[0] == 1'b0) begin
        r.pcw = 1'b1; r.xc = 1'b1;
        r.pc = (hl + 32'(int'(n[10:1]) * 4)) & 32'hFFFF_FFFC;
        r.lr = (v.pc + 32'd4) | 32'd1;
      end
    end else if (c[15:11] == 5'd31) begin
      r.pcw = 1'b1; r.lrw = 1'b1; r.st = 2'b01;
      r.pc = v.lr + 32'(int'(c[10:0]) * 2);
      r.lr = (v.pc + 32'd2) | 32'd1;
    end else if (c[15:11] == 5'd29) begin
      if (v.v5 && c[0] == 1'b0) begin
        r.pcw = 1'b1; r.lrw = 1'b1; r.xc = 1'b1; r.st = 2'b01;
        r.pc = (v.lr + 32'(int'(c[10:0]) * 2)) & 32'hFFFF_FFFC;
        r.lr = (v.pc + 32'd2) | 32'd1;
      end else begin
        r.st = 2'b10;
      end
    end
    return r;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    res_t e;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!(done || pc_we || link_we || flush || state_clr), "R10 strobes after reset",
        {27'd0, done, pc_we, link_we, flush, state_clr}, 32'd0);
    chk(pc_out == 0 && link_out == 0 && status == 0, "R10 values after reset",
        pc_out ^ link_out ^ 32'(status), 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      e = model(VEC[i]);
      big_end = VEC[i].big; isa_v5 = VEC[i].v5; fetch_word = VEC[i].word;
      pc_cur = VEC[i].pc; pc_read = VEC[i].pcr; link_in = VEC[i].lr;
      step = 1'b1;
      @(negedge clk);
      step = 1'b0;
      chk(done === 1'b1, $sformatf("R9 done vec %0d", i), 32'(done), 32'd1);
      chk(pc_we === e.pcw && flush === e.pcw,
          $sformatf("R9 R3 R5 pc_we/flush vec %0d", i), {30'd0, pc_we, flush},
          {30'd0, e.pcw, e.pcw});
      if (e.pcw)
        chk(pc_out === e.pc, $sformatf("R1 R3 R4 R6 R7 target vec %0d", i),
            pc_out, e.pc);
      chk(link_we === e.lrw, $sformatf("R2 R7 R8 link_we vec %0d", i),
          32'(link_we), 32'(e.lrw));
      if (e.lrw)
        chk(link_out === e.lr, $sformatf("R1 R2 R5 link value vec %0d", i),
            link_out, e.lr);
      chk(state_clr === e.xc, $sformatf("R4 R7 state_clr vec %0d", i),
          32'(state_clr), 32'(e.xc));
      chk(status === e.st, $sformatf("R7 R8 status vec %0d", i),
          32'(status), 32'(e.st));
    end

    // R9: strobes are single-cycle pulses
    @(negedge clk);
    chk(!(done || pc_we || link_we || flush || state_clr), "R9 idle pulse end",
        {27'd0, done, pc_we, link_we, flush, state_clr}, 32'd0);

    // R10: reset after activity
    fetch_word = 32'hF810_F001; big_end = 1'b0; step = 1'b1;
    @(negedge clk);
    step = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk(!(done || pc_we || flush) && pc_out == 0 && link_out == 0,
        "R10 reset clears outputs", pc_out | link_out, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule